// File: doc/BRIEF.md
# Post-Write Command Spacing Checker

This block sits next to the command port of a DDR2-style memory controller and watches every command issued to one device. After each WRITE it works out, in clocks, when the write data will have finished. From that point it derives when a READ may follow anywhere on the device, when the written bank may be precharged, and when another WRITE may start. It drives one legality vector per command type, with one bit per bank, so that a scheduler can ask whether a READ, WRITE, PRECHARGE or ACTIVATE to a given bank may go out in the current cycle. If a command is issued while its bit is low, a sticky violation flag is raised, and it stays high until software-independent logic pulses the clear input.

The write latency is taken as one clock less than the CAS latency, and the data phase takes half the burst length in clocks. The write-to-read time is raised to at least two clocks and is counted after the end of the data. Write recovery is also counted from the end of the data, whether or not any bytes were masked. A write with auto-precharge locks its own bank until recovery has finished. Other banks keep the normal rules, which already match the cross-bank delays that apply under concurrent auto-precharge.

The structure is one device-level gap machine for write-to-read, one for write-to-write, and eight per-bank recovery machines. Each gap machine has two states: GP_OPEN and GP_HOLD. START moves GP_OPEN to GP_HOLD. RELEASE moves GP_HOLD back to GP_OPEN once the count reaches zero. EXTEND keeps GP_HOLD and reloads the count with the later release time. Each bank machine has three states: BK_IDLE, BK_WR_RECOV and BK_AP_RECOV. A plain write moves BK_IDLE to BK_WR_RECOV. A write with auto-precharge moves BK_IDLE or BK_WR_RECOV to BK_AP_RECOV. RECOVER moves either recovery state back to BK_IDLE. The violation flag has two states, FL_CLEAR and FL_SET. TRIP moves FL_CLEAR to FL_SET. CLEAR moves FL_SET to FL_CLEAR, unless a new illegal command arrives in the same cycle.

Top module: `wsc_spacing_checker`

## Requirements
- R1: After reset, every bit of rd_ok, wr_ok, pre_ok and act_ok is 1 and violation is 0.
- R2: A WRITE (cmd_op 1) registered in cycle t holds rd_ok low for every bank until cycle t + (CL-1) + BL/2 + max(2, tWTR), where it goes high. BL is 8 when bl8_mode is 1 and 4 otherwise; CL is cas_lat, in the range 3 to 7.
- R3: A twtr_clk value below 2 is treated as 2 in the R2 delay.
- R4: After a WRITE in cycle t, wr_ok for banks not in auto-precharge is low until cycle t + BL/2 and is high from then on.
- R5: After a WRITE to bank b in cycle t, pre_ok[b] is low until cycle t + (CL-1) + BL/2 + twr_clk, where it goes high. pre_ok of other banks stays high.
- R6: After a WRITE with cmd_ap=1 to bank b, all four ok bits of bank b are low until the R5 release cycle. For every other bank, pre_ok and act_ok stay high in cycle t+1, while the read and write gates follow R2 and R4.
- R7: When writes overlap, each gate is released at the later of the release times the writes imply.
- R8: A command (cmd_op 0 READ, 1 WRITE, 2 PRECHARGE, 3 ACTIVATE) issued while its ok bit for cmd_bank is low sets violation in the next cycle. Violation then stays high while viol_clr is 0.
- R9: viol_clr in a cycle with no illegal command makes violation 0 in the next cycle. An illegal command in the same cycle as viol_clr wins, and violation ends up 1.
- R10: Legal READ, PRECHARGE and ACTIVATE commands change no ok bit and do not set violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | 0 READ, 1 WRITE, 2 PRECHARGE, 3 ACTIVATE |
| cmd_bank | input | 3 | Target bank |
| cmd_ap | input | 1 | Auto-precharge requested with the command |
| bl8_mode | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cas_lat | input | 3 | CAS latency in clocks (3 to 7) |
| twtr_clk | input | 4 | Write-to-read time in clocks |
| twr_clk | input | 4 | Write recovery time in clocks |
| viol_clr | input | 1 | Clears the violation flag |
| rd_ok | output | 8 | READ legal now, per bank |
| wr_ok | output | 8 | WRITE legal now, per bank |
| pre_ok | output | 8 | PRECHARGE legal now, per bank |
| act_ok | output | 8 | ACTIVATE legal now, per bank |
| violation | output | 1 | Sticky illegal-command flag |

## Verification
The bench samples each gate in the last blocked cycle and in the first open cycle. A release that is off by one clock, for example because the write latency or the data length was left out, therefore fails on one side or the other. It sets tWTR to 1, which would open reads a clock early if the two-clock floor were missing. It also checks a long BL8, CL5 case that separates the tWR path from the tWTR path. Overlapping writes to different banks catch a gate that takes the most recent load instead of the later release. Issuing viol_clr together with an illegal command catches a flag that lets the clear win and so loses the event.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PRE   = 2'd2,
        OP_ACT   = 2'd3
    } op_t;

    typedef enum logic {
        GP_OPEN,
        GP_HOLD
    } gap_st_t;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_WR_RECOV,
        BK_AP_RECOV
    } bank_st_t;

    typedef enum logic {
        FL_CLEAR,
        FL_SET
    } flag_st_t;

endpackage

// File: rtl/wsc_gap_fsm.sv
// Device-level countdown gate: closed for load clocks after start, keeps later release.
module wsc_gap_fsm
    import wsc_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             open_o
);

    gap_st_t          st, nxt_st;
    logic [CNT_W-1:0] cnt, nxt_cnt, rem;

    always_comb begin
        rem     = (cnt == '0) ? '0 : cnt - CNT_W'(1);
        nxt_cnt = (start && (load > rem)) ? load : rem;
        nxt_st  = st;
        unique case (st)
            GP_OPEN: nxt_st = (start && load != '0) ? GP_HOLD : GP_OPEN;   // START
            GP_HOLD: nxt_st = (nxt_cnt == '0) ? GP_OPEN : GP_HOLD;         // RELEASE / EXTEND
            default: nxt_st = GP_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= GP_OPEN;
            cnt <= '0;
        end else begin
            st  <= nxt_st;
            cnt <= nxt_cnt;
        end
    end

    always_comb begin
        unique case (st)
            GP_OPEN: open_o = 1'b1;
            GP_HOLD: open_o = 1'b0;
            default: open_o = 1'b1;
        endcase
    end

    AST_GAP_START_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load != '0) |=> !open_o); // R4

    AST_GAP_KEEPS_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GP_HOLD && cnt > CNT_W'(1)) |=> (st == GP_HOLD && cnt >= $past(cnt) - CNT_W'(1))); // R7

endmodule

// File: rtl/wsc_bank_fsm.sv
// Per-bank write recovery tracker with auto-precharge lock.
module wsc_bank_fsm
    import wsc_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             ap,
    input  logic [CNT_W-1:0] rec_load,
    output logic             idle_o,
    output logic             ap_busy_o
);

    bank_st_t         st, nxt_st;
    logic [CNT_W-1:0] cnt, nxt_cnt, rem;

    always_comb begin
        rem     = (cnt == '0) ? '0 : cnt - CNT_W'(1);
        nxt_cnt = (wr_hit && (rec_load > rem)) ? rec_load : rem;
        nxt_st  = st;
        unique case (st)
            BK_IDLE: begin
                if (wr_hit && rec_load != '0)
                    nxt_st = ap ? BK_AP_RECOV : BK_WR_RECOV;
            end
            BK_WR_RECOV: begin
                if (nxt_cnt == '0)       nxt_st = BK_IDLE;       // RECOVER
                else if (wr_hit && ap)   nxt_st = BK_AP_RECOV;
                else                     nxt_st = BK_WR_RECOV;
            end
            BK_AP_RECOV: begin
                nxt_st = (nxt_cnt == '0) ? BK_IDLE : BK_AP_RECOV;  // RECOVER
            end
            default: nxt_st = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt_st;
            cnt <= nxt_cnt;
        end
    end

    always_comb begin
        idle_o    = 1'b0;
        ap_busy_o = 1'b0;
        unique case (st)
            BK_IDLE:     idle_o    = 1'b1;
            BK_WR_RECOV: idle_o    = 1'b0;
            BK_AP_RECOV: ap_busy_o = 1'b1;
            default:     idle_o    = 1'b1;
        endcase
    end

    AST_BANK_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && rec_load > CNT_W'(1)) |=> !idle_o); // R5

    AST_BANK_AP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ap && rec_load > CNT_W'(1)) |=> ap_busy_o); // R6

endmodule

// File: rtl/wsc_sticky_flag.sv
// Sticky event flag; a new event wins over a clear in the same cycle.
module wsc_sticky_flag
    import wsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    flag_st_t st, nxt_st;

    always_comb begin
        nxt_st = st;
        unique case (st)
            FL_CLEAR: nxt_st = set ? FL_SET : FL_CLEAR;               // TRIP
            FL_SET:   nxt_st = (clr && !set) ? FL_CLEAR : FL_SET;     // CLEAR
            default:  nxt_st = FL_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= FL_CLEAR;
        else        st <= nxt_st;
    end

    always_comb begin
        unique case (st)
            FL_SET:  flag = 1'b1;
            default: flag = 1'b0;
        endcase
    end

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R8

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag); // R9

endmodule

// File: rtl/wsc_spacing_checker.sv
module wsc_spacing_checker
    import wsc_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CL_W      = 3,
    parameter int T_W       = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_op,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input  logic                         cmd_ap,
    input  logic                         bl8_mode,
    input  logic [CL_W-1:0]              cas_lat,
    input  logic [T_W-1:0]               twtr_clk,
    input  logic [T_W-1:0]               twr_clk,
    input  logic                         viol_clr,
    output logic [NUM_BANKS-1:0]         rd_ok,
    output logic [NUM_BANKS-1:0]         wr_ok,
    output logic [NUM_BANKS-1:0]         pre_ok,
    output logic [NUM_BANKS-1:0]         act_ok,
    output logic                         violation
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CNT_W  = $clog2((2 ** CL_W) + 8 + (2 ** T_W) + 1);

    // Delay arithmetic, all in clocks from the WRITE edge.
    logic [CNT_W-1:0] cl_x, half_x, wtr_x, data_end;
    logic [CNT_W-1:0] rd_load, ww_load, rec_load;

    always_comb begin
        cl_x     = CNT_W'(cas_lat);
        half_x   = bl8_mode ? CNT_W'(4) : CNT_W'(2);
        wtr_x    = (twtr_clk < T_W'(2)) ? CNT_W'(2) : CNT_W'(twtr_clk);
        data_end = cl_x - CNT_W'(1) + half_x;
        rd_load  = data_end + wtr_x - CNT_W'(1);
        rec_load = data_end + CNT_W'(twr_clk) - CNT_W'(1);
        ww_load  = half_x - CNT_W'(1);
    end

    op_t  op;
    logic wr_fire;
    assign op      = op_t'(cmd_op);
    assign wr_fire = cmd_valid && (op == OP_WRITE);

    logic rd_open, ww_open;

    wsc_gap_fsm #(.CNT_W(CNT_W)) u_rd_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_fire),
        .load   (rd_load),
        .open_o (rd_open)
    );

    wsc_gap_fsm #(.CNT_W(CNT_W)) u_ww_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_fire),
        .load   (ww_load),
        .open_o (ww_open)
    );

    logic [NUM_BANKS-1:0] bank_idle, bank_ap;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_fire && (cmd_bank == BANK_W'(b));

        wsc_bank_fsm #(.CNT_W(CNT_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (hit),
            .ap        (cmd_ap),
            .rec_load  (rec_load),
            .idle_o    (bank_idle[b]),
            .ap_busy_o (bank_ap[b])
        );

        assign rd_ok[b]  = rd_open & ~bank_ap[b];
        assign wr_ok[b]  = ww_open & ~bank_ap[b];
        assign pre_ok[b] = bank_idle[b];
        assign act_ok[b] = ~bank_ap[b];
    end

    logic legal, illegal;

    always_comb begin
        legal = 1'b1;
        unique case (op)
            OP_READ:  legal = rd_ok[cmd_bank];
            OP_WRITE: legal = wr_ok[cmd_bank];
            OP_PRE:   legal = pre_ok[cmd_bank];
            OP_ACT:   legal = act_ok[cmd_bank];
            default:  legal = 1'b1;
        endcase
        illegal = cmd_valid && !legal;
    end

    wsc_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (illegal),
        .clr   (viol_clr),
        .flag  (violation)
    );

    AST_RD_BLOCKED_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (rd_ok == '0)); // R2

    AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> violation); // R8

    AST_OTHER_BANK_PRE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && cmd_ap && $past(pre_ok) == '1 && !$past(wr_fire))
            |=> ($countones(pre_ok) >= NUM_BANKS - 1)); // R6

endmodule

// File: tb/wsc_spacing_checker_test.sv
module wsc_spacing_checker_test;

    localparam logic [1:0] C_RD = 2'd0, C_WR = 2'd1, C_PRE = 2'd2, C_ACT = 2'd3;
    localparam int K_RD = 0, K_WR = 1, K_PRE = 2, K_ACT = 3, K_VIO = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [2:0] cmd_bank = 3'd0;
    logic       cmd_ap = 1'b0;
    logic       bl8_mode = 1'b0;
    logic [2:0] cas_lat = 3'd3;
    logic [3:0] twtr_clk = 4'd3;
    logic [3:0] twr_clk = 4'd3;
    logic       viol_clr = 1'b0;
    logic [7:0] rd_ok, wr_ok, pre_ok, act_ok;
    logic       violation;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wsc_spacing_checker uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .bl8_mode(bl8_mode),
        .cas_lat(cas_lat), .twtr_clk(twtr_clk), .twr_clk(twr_clk),
        .viol_clr(viol_clr), .rd_ok(rd_ok), .wr_ok(wr_ok), .pre_ok(pre_ok),
        .act_ok(act_ok), .violation(violation)
    );

    typedef struct {
        int    cyc;
        int    kind;
        int    bank;
        bit    val;
        string req;
    } exp_t;

    exp_t sbq[$];

    task automatic expect_at(int c, int k, int b, bit v, string r);
        sbq.push_back('{c, k, b, v, r});
    endtask

    function automatic bit probe(int k, int b);
        case (k)
            K_RD:    return rd_ok[b];
            K_WR:    return wr_ok[b];
            K_PRE:   return pre_ok[b];
            K_ACT:   return act_ok[b];
            default: return violation;
        endcase
    endfunction

    // Monitor: pops due expectations and compares away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].cyc <= cyc) begin
                    bit a;
                    a = probe(sbq[i].kind, sbq[i].bank);
                    total++;
                    if (sbq[i].cyc < cyc || a !== sbq[i].val) begin
                        bad++;
                        $display("FAIL %s kind=%0d bank=%0d cycle=%0d actual=%0b expected=%0b",
                                 sbq[i].req, sbq[i].kind, sbq[i].bank, sbq[i].cyc, a, sbq[i].val);
                    end
                    sbq.delete(i);
                end
            end
        end
    end

    task automatic chk(bit ok, string r, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
        end
    endtask

    task automatic put(logic [1:0] op, int b, bit ap, output int t);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_bank  = 3'(b);
        cmd_ap    = ap;
        t = cyc;
    endtask

    task automatic gap(int n);
        repeat (n) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            cmd_ap    = 1'b0;
            viol_clr  = 1'b0;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t, u;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_ok == 8'hFF, "R1 rd_ok", rd_ok, 8'hFF);
        chk(wr_ok == 8'hFF, "R1 wr_ok", wr_ok, 8'hFF);
        chk(pre_ok == 8'hFF, "R1 pre_ok", pre_ok, 8'hFF);
        chk(act_ok == 8'hFF, "R1 act_ok", act_ok, 8'hFF);
        chk(violation == 1'b0, "R1 violation", violation, 0);

        // CL3 BL4 tWTR3 tWR3: read gap 7, recovery 7, write spacing 2
        put(C_WR, 2, 0, t);
        expect_at(t + 6, K_RD, 0, 0, "R2");
        expect_at(t + 7, K_RD, 0, 1, "R2");
        expect_at(t + 7, K_RD, 6, 1, "R2");
        expect_at(t + 1, K_WR, 3, 0, "R4");
        expect_at(t + 2, K_WR, 3, 1, "R4");
        expect_at(t + 6, K_PRE, 2, 0, "R5");
        expect_at(t + 7, K_PRE, 2, 1, "R5");
        expect_at(t + 1, K_PRE, 5, 1, "R5");
        expect_at(t + 1, K_ACT, 2, 1, "R5");
        gap(10);

        // R3: tWTR of 1 rounds to 2, read gap 6
        twtr_clk = 4'd1;
        put(C_WR, 0, 0, t);
        expect_at(t + 5, K_RD, 1, 0, "R3");
        expect_at(t + 6, K_RD, 1, 1, "R3");
        gap(10);

        // BL8 CL5 tWTR2 tWR5: read gap 10, write spacing 4, recovery 13
        bl8_mode = 1'b1; cas_lat = 3'd5; twtr_clk = 4'd2; twr_clk = 4'd5;
        put(C_WR, 4, 0, t);
        expect_at(t + 9, K_RD, 4, 0, "R2");
        expect_at(t + 10, K_RD, 4, 1, "R2");
        expect_at(t + 3, K_WR, 0, 0, "R4");
        expect_at(t + 4, K_WR, 0, 1, "R4");
        expect_at(t + 12, K_PRE, 4, 0, "R5");
        expect_at(t + 13, K_PRE, 4, 1, "R5");
        gap(16);
        bl8_mode = 1'b0; cas_lat = 3'd3; twtr_clk = 4'd3; twr_clk = 4'd3;

        // R6: write with auto-precharge to bank 1
        put(C_WR, 1, 1, t);
        expect_at(t + 1, K_PRE, 4, 1, "R6");
        expect_at(t + 1, K_ACT, 4, 1, "R6");
        expect_at(t + 2, K_WR, 4, 1, "R6");
        expect_at(t + 6, K_RD, 4, 0, "R6");
        expect_at(t + 7, K_RD, 4, 1, "R6");
        expect_at(t + 6, K_ACT, 1, 0, "R6");
        expect_at(t + 6, K_WR, 1, 0, "R6");
        expect_at(t + 6, K_PRE, 1, 0, "R6");
        expect_at(t + 7, K_ACT, 1, 1, "R6");
        expect_at(t + 7, K_RD, 1, 1, "R6");
        expect_at(t + 7, K_PRE, 1, 1, "R6");
        gap(10);

        // R7: overlapping writes, later release wins
        put(C_WR, 0, 0, t);
        gap(2);
        put(C_WR, 5, 0, u);
        expect_at(t + 8, K_RD, 0, 0, "R7");
        expect_at(t + 9, K_RD, 0, 1, "R7");
        expect_at(t + 7, K_PRE, 0, 1, "R7");
        expect_at(t + 8, K_PRE, 5, 0, "R7");
        expect_at(t + 9, K_PRE, 5, 1, "R7");
        gap(12);

        // R8: illegal READ right after a WRITE
        put(C_WR, 3, 0, t);
        gap(1);
        put(C_RD, 3, 0, u);
        expect_at(t + 1, K_VIO, 0, 0, "R8");
        expect_at(t + 2, K_VIO, 0, 1, "R8");
        expect_at(t + 5, K_VIO, 0, 1, "R8");
        gap(6);
        viol_clr = 1'b1;                 // cycle t+7
        expect_at(t + 7, K_VIO, 0, 1, "R9");
        expect_at(t + 8, K_VIO, 0, 0, "R9");
        gap(8);

        // R9: illegal command together with clear, set wins
        put(C_WR, 2, 0, t);
        gap(1);
        put(C_RD, 2, 0, u);
        viol_clr = 1'b1;
        expect_at(t + 1, K_VIO, 0, 0, "R9");
        expect_at(t + 2, K_VIO, 0, 1, "R9");
        gap(8);
        viol_clr = 1'b1;
        u = cyc;
        expect_at(u + 1, K_VIO, 0, 0, "R9");
        gap(3);

        // R10: legal READ, PRECHARGE, ACTIVATE leave everything open
        put(C_RD, 3, 1, t);
        expect_at(t + 1, K_RD, 0, 1, "R10");
        expect_at(t + 1, K_RD, 3, 1, "R10");
        expect_at(t + 1, K_WR, 3, 1, "R10");
        expect_at(t + 1, K_PRE, 3, 1, "R10");
        expect_at(t + 1, K_VIO, 0, 0, "R10");
        gap(1);
        put(C_PRE, 3, 0, u);
        gap(1);
        put(C_ACT, 3, 0, u);
        expect_at(t + 3, K_PRE, 3, 1, "R10");
        expect_at(t + 3, K_ACT, 3, 1, "R10");
        expect_at(t + 3, K_RD, 3, 1, "R10");
        expect_at(t + 4, K_VIO, 0, 0, "R10");
        gap(8);

        chk(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule